// File: doc/BRIEF.md
# Interleaved three-phase PWM generator

This block drives three interleaved half-bridge phases from one free-running up-counter. Each phase makes a single switching waveform from two compare events on the shared count. Phase 2 is placed one third of a period after phase 1, and phase 3 two thirds after phase 1. A high-side and a low-side gate are derived from each waveform. The low side is the inverse of the high side, and every turn-on of either gate is held back by a common dead-time count.

Software writes period and compare values over a small register port into shadow copies. The shadow copies do nothing until a one-shot transfer is armed. At the next counter wrap the whole shadow set moves into the active set on a single clock edge. A change of switching frequency therefore never runs a period with a mix of old and new values. The arm strobe is refused when the shadow set is inconsistent.

Top module: `pwm3_interleave`

## Requirements
- R1: During and right after reset all six gate outputs are low. The counter starts at zero. Shadow and active sets hold the default period 333 and the default compares: phase-1 off 167, phase-2 off 278, phase-2 on 111, phase-3 on 222, phase-3 off 56. The dead time defaults to 40.
- R2: The counter runs from 0 up to the active period P and then wraps to 0, so one switching period lasts P+1 clocks. Phase 1 turns on in the cycle after count 0 and turns off in the cycle after count equals its off compare A1. Its high time is therefore A1 clocks.
- R3: Phase 2 turns on after count equals B2 and off after count equals A2, so it is high for A2-B2 clocks and starts B2 clocks after phase 1. Phase 3 turns on after count equals A3 and off after count equals B3, so it is high for P+1-A3+B3 clocks and starts A3 clocks after phase 1.
- R4: For a raw high time W and dead time D, each high-side gate is on for W-D clocks per period and each low-side gate for P+1-W-D clocks. A write to the dead time takes effect at once, without arming.
- R5: A gate whose raw pulse is not longer than D stays off for the whole period. The high and low gate of a phase are never on in the same cycle.
- R6: Writes to the period and compare shadows change no output until a transfer is armed. The active set only changes on the edge that ends a cycle with count equal to P.
- R7: Arming is refused unless every shadow compare is below the shadow period and the phase-2 on compare is below the phase-1 off compare. The same test is repeated at the wrap, and an inconsistent set is held back there. The active set always passes this test.
- R8: If arm is asserted in the cycle whose count equals P, the transfer takes place on that wrap. The new period begins in the next cycle.
- R9: Shadow writes made after a valid arm and before the wrap are part of the transferred set.
- R10: Arming covers one transfer only. Shadow writes after that transfer, with no new arm, change nothing.
- R11: Write addresses: 0 period, 1 phase-1 off, 2 phase-2 off, 3 phase-2 on, 4 phase-3 on, 5 phase-3 off, 6 dead time. Address 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (R11) |
| wr_data | input | CW | Write value |
| arm | input | 1 | One-shot transfer arm strobe |
| ph1_hi | output | 1 | Phase 1 high-side gate |
| ph1_lo | output | 1 | Phase 1 low-side gate |
| ph2_hi | output | 1 | Phase 2 high-side gate |
| ph2_lo | output | 1 | Phase 2 low-side gate |
| ph3_hi | output | 1 | Phase 3 high-side gate |
| ph3_lo | output | 1 | Phase 3 low-side gate |

## Verification
A gate's raw level changes one clock after its compare match. The gate itself follows D clocks later. A valid arm produces the new period in the cycle straight after the wrap edge.

The bench waits until at least two full new periods have run after the expected transfer before it measures a steady-state pattern. It then counts high cycles and edge positions over a window of exactly P+1 clocks, so the alignment of the window does not matter.

For the wrap-timing case it runs with zero dead time. It finds count 1 from the first phase-1 rise, counts forward P-1 cycles to reach count P, and asserts arm there. It then checks the very next P+1 cycles against the new on-time, which would differ by a whole period if the transfer were late.

// File: rtl/pwm3_interleave.sv
module pwm3_interleave #(
  parameter int CW      = 16,
  parameter int DW      = 8,
  parameter int DEF_PRD = 333,
  parameter int DEF_P1A = 167,
  parameter int DEF_P2A = 278,
  parameter int DEF_P2B = 111,
  parameter int DEF_P3A = 222,
  parameter int DEF_P3B = 56,
  parameter int DEF_DT  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          arm,
  output logic          ph1_hi,
  output logic          ph1_lo,
  output logic          ph2_hi,
  output logic          ph2_lo,
  output logic          ph3_hi,
  output logic          ph3_lo
);
  localparam int NPH = 3;

  logic [CW-1:0] sh_prd, sh_p1a, sh_p2a, sh_p2b, sh_p3a, sh_p3b;
  logic [CW-1:0] ac_prd, ac_p1a, ac_p2a, ac_p2b, ac_p3a, ac_p3b;
  logic [DW-1:0] dt;
  logic [CW-1:0] cnt;
  logic          armed;
  logic [NPH-1:0] raw, raw_n, hi, lo;

  function automatic logic set_ok(input logic [CW-1:0] p, a1, a2, b2, a3, b3);
    return (a1 < p) && (a2 < p) && (b2 < p) && (a3 < p) && (b3 < p) && (b2 < a1);
  endfunction

  wire sh_ok = set_ok(sh_prd, sh_p1a, sh_p2a, sh_p2b, sh_p3a, sh_p3b);
  wire wrap  = (cnt == ac_prd);
  wire take  = wrap && (armed || arm) && sh_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_prd <= CW'(DEF_PRD);
      sh_p1a <= CW'(DEF_P1A);
      sh_p2a <= CW'(DEF_P2A);
      sh_p2b <= CW'(DEF_P2B);
      sh_p3a <= CW'(DEF_P3A);
      sh_p3b <= CW'(DEF_P3B);
      dt     <= DW'(DEF_DT);
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: sh_prd <= wr_data;
        3'd1: sh_p1a <= wr_data;
        3'd2: sh_p2a <= wr_data;
        3'd3: sh_p2b <= wr_data;
        3'd4: sh_p3a <= wr_data;
        3'd5: sh_p3b <= wr_data;
        3'd6: dt     <= wr_data[DW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_prd <= CW'(DEF_PRD);
      ac_p1a <= CW'(DEF_P1A);
      ac_p2a <= CW'(DEF_P2A);
      ac_p2b <= CW'(DEF_P2B);
      ac_p3a <= CW'(DEF_P3A);
      ac_p3b <= CW'(DEF_P3B);
    end else if (take) begin
      ac_prd <= sh_prd;
      ac_p1a <= sh_p1a;
      ac_p2a <= sh_p2a;
      ac_p2b <= sh_p2b;
      ac_p3a <= sh_p3a;
      ac_p3b <= sh_p3b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed <= 1'b0;
    else if (take)          armed <= 1'b0;
    else if (arm && sh_ok)  armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_comb begin
    raw_n = raw;
    if (cnt == ac_p1a)      raw_n[0] = 1'b0;
    else if (cnt == '0)     raw_n[0] = 1'b1;
    if (cnt == ac_p2a)      raw_n[1] = 1'b0;
    else if (cnt == ac_p2b) raw_n[1] = 1'b1;
    if (cnt == ac_p3a)      raw_n[2] = 1'b1;
    else if (cnt == ac_p3b) raw_n[2] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_n;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_db
    logic [DW-1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  age <= '0;
      else if (raw_n[g] != raw[g]) age <= '0;
      else if (age != '1)          age <= age + 1'b1;
    end
    assign hi[g] =  raw[g] & (age >= dt);
    assign lo[g] = ~raw[g] & (age >= dt);
  end

  assign ph1_hi = hi[0];
  assign ph1_lo = lo[0];
  assign ph2_hi = hi[1];
  assign ph2_lo = lo[1];
  assign ph3_hi = hi[2];
  assign ph3_lo = lo[2];

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R2

  AST_ACT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ac_prd, ac_p1a, ac_p2a, ac_p2b, ac_p3a, ac_p3b}) |-> $past(wrap)); // R6

  AST_ACT_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok(ac_prd, ac_p1a, ac_p2a, ac_p2b, ac_p3a, ac_p3b)); // R7

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !armed); // R10

  AST_ARM_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && arm && sh_ok) |=> (ac_prd == $past(sh_prd))); // R8
endmodule

// File: tb/sim_pwm3_interleave.sv
module sim_pwm3_interleave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        arm = 1'b0;
  logic ph1_hi, ph1_lo, ph2_hi, ph2_lo, ph3_hi, ph3_lo;
  logic [2:0] hv, lv;

  int nchk = 0;
  int nbad = 0;
  int hc[3], lc[3], rs[3];
  bit ovl;

  always #10 clk = ~clk;

  pwm3_interleave u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .arm(arm),
    .ph1_hi(ph1_hi), .ph1_lo(ph1_lo), .ph2_hi(ph2_hi), .ph2_lo(ph2_lo),
    .ph3_hi(ph3_hi), .ph3_lo(ph3_lo)
  );

  assign hv = {ph3_hi, ph2_hi, ph1_hi};
  assign lv = {ph3_lo, ph2_lo, ph1_lo};

  localparam int NV = 6;
  localparam int VEC [NV][7] = '{
    '{59, 30, 50, 20, 40, 10, 0},
    '{29, 15, 25, 10, 20,  5, 3},
    '{99, 50, 83, 33, 67, 17, 8},
    '{11,  6, 10,  4,  8,  2, 4},
    '{19,  3, 12,  2, 14,  4, 5},
    '{47, 24, 40, 16, 32,  8, 2}
  };

  function automatic int mx(input int v);
    return (v > 0) ? v : 0;
  endfunction

  function automatic void chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic shadows(input int p, input int a1, input int a2, input int b2, input int a3, input int b3);
    wr(0, p); wr(1, a1); wr(2, a2); wr(3, b2); wr(4, a3); wr(5, b3);
  endtask

  task automatic pulse_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_p1_rise();
    logic prev;
    int guard;
    prev = ph1_hi;
    @(negedge clk);
    guard = 0;
    while (!(ph1_hi && !prev) && guard < 2000) begin
      prev = ph1_hi;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic measure(input int p);
    logic [2:0] prev;
    prev = hv;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin hc[k] = 0; lc[k] = 0; rs[k] = -1; end
    ovl = 1'b0;
    for (int i = 0; i <= p; i++) begin
      for (int k = 0; k < 3; k++) begin
        if (hv[k]) hc[k]++;
        if (lv[k]) lc[k]++;
        if (hv[k] && !prev[k]) rs[k] = i;
        if (hv[k] && lv[k]) ovl = 1'b1;
      end
      prev = hv;
      @(negedge clk);
    end
  endtask

  task automatic expect_cfg(input int p, input int a1, input int a2, input int b2,
                            input int a3, input int b3, input int d, input string tag);
    int w[3];
    w[0] = a1; w[1] = a2 - b2; w[2] = p + 1 - a3 + b3;
    measure(p);
    for (int k = 0; k < 3; k++) begin
      chk($sformatf("%s R4 phase%0d high-side width", tag, k + 1), hc[k], mx(w[k] - d));
      chk($sformatf("%s R4 phase%0d low-side width", tag, k + 1), lc[k], mx(p + 1 - w[k] - d));
    end
    if (mx(w[0] - d) > 0 && mx(w[1] - d) > 0)
      chk({tag, " R3 phase2 offset"}, (rs[1] - rs[0] + p + 1) % (p + 1), b2);
    if (mx(w[0] - d) > 0 && mx(w[2] - d) > 0)
      chk({tag, " R3 phase3 offset"}, (rs[2] - rs[0] + p + 1) % (p + 1), a3);
    chk({tag, " R5 overlap"}, int'(ovl), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int cnt1;
    repeat (3) @(negedge clk);
    chk("R1 gates in reset", int'({hv, lv}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gates after reset", int'({hv, lv}), 0);

    idle(700);
    expect_cfg(333, 167, 278, 111, 222, 56, 40, "R1 R2 default");

    for (int v = 0; v < NV; v++) begin
      wr(6, VEC[v][6]);
      shadows(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      pulse_arm();
      idle(800);
      expect_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6],
                 $sformatf("R2 R11 vec%0d", v));
    end

    wr(6, 5);
    shadows(19, 3, 12, 2, 14, 4);
    pulse_arm();
    idle(300);
    expect_cfg(19, 3, 12, 2, 14, 4, 5, "R5 suppressed");

    shadows(49, 25, 40, 16, 33, 8);
    wr(7, 3);
    idle(200);
    expect_cfg(19, 3, 12, 2, 14, 4, 5, "R6 R11 no arm");

    wr(4, 60);
    pulse_arm();
    idle(200);
    expect_cfg(19, 3, 12, 2, 14, 4, 5, "R7 compare over period");
    wr(4, 33);
    wr(3, 30);
    pulse_arm();
    idle(200);
    expect_cfg(19, 3, 12, 2, 14, 4, 5, "R7 phase2 on past phase1 off");

    wr(6, 0);
    shadows(39, 20, 33, 13, 27, 7);
    pulse_arm();
    idle(200);
    expect_cfg(39, 20, 33, 13, 27, 7, 0, "R2 R8 setup");
    shadows(59, 30, 50, 20, 40, 10);
    wait_p1_rise();
    idle(38);
    pulse_arm();
    cnt1 = 0;
    for (int i = 0; i < 60; i++) begin
      if (ph1_hi) cnt1++;
      @(negedge clk);
    end
    chk("R8 first period after arm on wrap", cnt1, 30);

    wait_p1_rise();
    pulse_arm();
    shadows(79, 40, 66, 26, 53, 13);
    idle(300);
    expect_cfg(79, 40, 66, 26, 53, 13, 0, "R9 late shadow writes");

    shadows(29, 15, 25, 10, 20, 5);
    idle(300);
    expect_cfg(79, 40, 66, 26, 53, 13, 0, "R10 arm consumed");

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule